// File: doc/BRIEF.md
# Chainable Serial Status Port

This block is the serial slave front end of a four-channel switch controller. A host frames a transfer by pulling the active-low select low. It then clocks command bits in on the data input and reads a 16-bit status word back on the data output. Select, serial clock and data input are all brought into the system clock domain through synchronizers, and every action of the block happens on a system clock edge.

When select rises, the block counts the serial clock rising edges of the frame. Only a nonzero multiple of 16 makes the frame valid. For a valid frame, the last 16 received bits become the accepted command: a one-cycle write strobe is raised for the register that the command's address field names, and the command word is presented with it. A frame of any other length leaves no trace. After its own 16 status bits, the output replays the input bits in arrival order, so several parts can share one select line in a chain.

The status word is frozen when select falls. It combines the watchdog bit and the low five bits of the previously accepted command with sticky supply and fault flags. Its low nibble comes from an external source, chosen by a persistent selection field that only a write to address 0 changes.

Top module: `spi_status_frontend`

## Requirements
- R1: After reset so_oe is 0, reg_wr_en is all zero, stat_sel is 0, and the first status word carries zeros in bits 15:4.
- R2: so_oe is 0 and so is 0 while cs_n is high; so_oe is 1 during a frame.
- R3: A frame is valid only if its count of sclk rising edges is nonzero and divisible by 16; the count saturates at 2^CNT_W-1, so longer frames are invalid.
- R4: At the end of a valid frame, reg_wr_en pulses for one cycle with exactly one bit set, bit index = reg_wr_data[15:13], and reg_wr_data = the last 16 bits received, first received bit in bit 15.
- R5: An invalid frame produces no strobe and changes neither stat_sel, nor the status echo fields, nor the sticky flags.
- R6: Once a frame has passed 16 bits, so returns the frame's SI bits in the order they arrived, each delayed by 16 bit periods.
- R7: Status bit 15 equals bit 12 of the previously accepted command; status bits 12:8 equal bits 4:0 of that command.
- R8: Status bit 14 (undervoltage) and bit 13 (overvoltage) are 1 if the input was high at any time since the last valid frame end; at that end the flags reload from the live inputs.
- R9: Status bits 7:4 hold sticky fault flags of channels 3..0 (bit 7 = channel 3), with the same capture and reload rules as R8.
- R10: stat_sel loads bits 4:0 of a valid command whose address field is 0, and holds its value otherwise; status bits 3:0 are stat_nib as seen when select falls.
- R11: SI is sampled on the sclk rising edge and so changes after the sclk falling edge; status bit 15 appears on so once select has fallen, before the first sclk edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low frame select |
| si | input | 1 | Serial data in |
| so | output | 1 | Serial data out, 0 when not enabled |
| so_oe | output | 1 | Enable for the serial output driver |
| fault_in | input | 4 | Live fault flags, bit n = channel n |
| uv_in | input | 1 | Live undervoltage indication |
| ov_in | input | 1 | Live overvoltage indication |
| stat_nib | input | 4 | Per-channel content selected by stat_sel |
| stat_sel | output | 5 | Current status selection field |
| reg_wr_en | output | 8 | One-hot write strobe per register address |
| reg_wr_data | output | 16 | Accepted command word |

## Verification
The hardest case to reach is a frame longer than 16 bits, where the replayed input and the frame-length check meet. The replay has to be told apart from the status word, and only the final 16 bits may be written. The bench drives a 32-bit frame whose two halves carry different patterns and different addresses. It then checks the echoed half on so and the strobe contents separately. Frames one bit short, one bit long and empty run between accepted commands, so that any state they disturb shows up in the next status word.

// File: rtl/spi_stat_pkg.sv
package spi_stat_pkg;
    localparam int WORD_W   = 16;
    localparam int ADDR_W   = 3;
    localparam int NREG     = 1 << ADDR_W;
    localparam int NFLT     = 4;
    localparam int SEL_W    = 5;
    localparam int NIB_W    = 4;
    localparam logic [ADDR_W-1:0] SEL_ADDR = '0;

    typedef struct packed {
        logic [ADDR_W-1:0]            addr;
        logic                         wd;
        logic [WORD_W-ADDR_W-2:0]     body;
    } cmd_t;

    typedef struct packed {
        logic              wd;
        logic              uv;
        logic              ov;
        logic [SEL_W-1:0]  echo;
        logic [NFLT-1:0]   fault;
        logic [NIB_W-1:0]  nib;
    } stat_t;

    function automatic stat_t build_status(input cmd_t prev, input logic uv,
                                           input logic ov, input logic [NFLT-1:0] flt,
                                           input logic [NIB_W-1:0] nib);
        stat_t s;
        s.wd    = prev.wd;
        s.uv    = uv;
        s.ov    = ov;
        s.echo  = prev.body[SEL_W-1:0];
        s.fault = flt;
        s.nib   = nib;
        return s;
    endfunction

    function automatic logic frame_len_ok(input logic [31:0] n);
        return (n != 0) && ((n % WORD_W) == 0);
    endfunction
endpackage

// File: rtl/sync_chain.sv
module sync_chain #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] r;

    always_ff @(posedge clk) begin
        if (rst) r <= {STAGES{RST_VAL}};
        else     r <= {r[STAGES-2:0], d};
    end

    assign q = r[STAGES-1];
endmodule

// File: rtl/sync_edge.sv
module sync_edge #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q,
    output logic rise,
    output logic fall
);
    logic q_d;

    sync_chain #(.STAGES(STAGES), .RST_VAL(RST_VAL)) i_chain (
        .clk(clk), .rst(rst), .d(d), .q(q)
    );

    always_ff @(posedge clk) begin
        if (rst) q_d <= RST_VAL;
        else     q_d <= q;
    end

    assign rise = q & ~q_d;
    assign fall = ~q & q_d;
endmodule

// File: rtl/spi_shift.sv
module spi_shift import spi_stat_pkg::*; #(
    parameter int CNT_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              active,
    input  logic              start,
    input  logic              sck_rise,
    input  logic              sck_fall,
    input  logic              si_s,
    input  logic [WORD_W-1:0] load,
    output logic              so_bit,
    output logic [WORD_W-1:0] rx_word,
    output logic              len_ok
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [WORD_W-1:0] tx_q, rx_q;
    logic              hold_q;
    logic [CNT_W-1:0]  cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_q   <= '0;
            rx_q   <= '0;
            hold_q <= 1'b0;
            cnt_q  <= '0;
        end else if (start) begin
            tx_q  <= load;
            cnt_q <= '0;
        end else if (active) begin
            if (sck_rise) begin
                rx_q   <= {rx_q[WORD_W-2:0], si_s};
                hold_q <= si_s;
                if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
            end
            if (sck_fall) tx_q <= {tx_q[WORD_W-2:0], hold_q};
        end
    end

    assign so_bit  = tx_q[WORD_W-1];
    assign rx_word = rx_q;
    assign len_ok  = frame_len_ok(32'(cnt_q));
endmodule

// File: rtl/spi_cmd_regs.sv
module spi_cmd_regs import spi_stat_pkg::*; (
    input  logic              clk,
    input  logic              rst,
    input  logic              commit,
    input  cmd_t              rx_cmd,
    input  logic [NFLT-1:0]   flt_in,
    input  logic              uv_in,
    input  logic              ov_in,
    input  logic [NIB_W-1:0]  nib_in,
    output stat_t             status,
    output logic [SEL_W-1:0]  stat_sel,
    output logic [NREG-1:0]   wr_en,
    output logic [WORD_W-1:0] wr_data
);
    cmd_t            prev_q;
    logic [NFLT-1:0] flt_q;
    logic            uv_q, ov_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q   <= '0;
            flt_q    <= '0;
            uv_q     <= 1'b0;
            ov_q     <= 1'b0;
            stat_sel <= '0;
            wr_en    <= '0;
            wr_data  <= '0;
        end else begin
            wr_en <= '0;
            if (commit) begin
                prev_q  <= rx_cmd;
                wr_en   <= NREG'(1) << rx_cmd.addr;
                wr_data <= rx_cmd;
                if (rx_cmd.addr == SEL_ADDR) stat_sel <= rx_cmd.body[SEL_W-1:0];
                flt_q <= flt_in;
                uv_q  <= uv_in;
                ov_q  <= ov_in;
            end else begin
                flt_q <= flt_q | flt_in;
                uv_q  <= uv_q | uv_in;
                ov_q  <= ov_q | ov_in;
            end
        end
    end

    assign status = build_status(prev_q, uv_q, ov_q, flt_q, nib_in);
endmodule

// File: rtl/spi_status_frontend.sv
module spi_status_frontend import spi_stat_pkg::*; #(
    parameter int CNT_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sclk,
    input  logic              cs_n,
    input  logic              si,
    output logic              so,
    output logic              so_oe,
    input  logic [NFLT-1:0]   fault_in,
    input  logic              uv_in,
    input  logic              ov_in,
    input  logic [NIB_W-1:0]  stat_nib,
    output logic [SEL_W-1:0]  stat_sel,
    output logic [NREG-1:0]   reg_wr_en,
    output logic [WORD_W-1:0] reg_wr_data
);
    logic cs_q, cs_rise, cs_fall;
    logic sck_q, sck_rise, sck_fall;
    logic si_s, so_bit, len_ok, oe_q;
    logic [WORD_W-1:0] rx_word;
    stat_t status;

    sync_edge #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_cs_sync (
        .clk(clk), .rst(rst), .d(cs_n), .q(cs_q), .rise(cs_rise), .fall(cs_fall)
    );

    sync_edge #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) i_sck_sync (
        .clk(clk), .rst(rst), .d(sclk), .q(sck_q), .rise(sck_rise), .fall(sck_fall)
    );

    sync_chain #(.STAGES(SYNC_STAGES + 1), .RST_VAL(1'b0)) i_si_sync (
        .clk(clk), .rst(rst), .d(si), .q(si_s)
    );

    spi_shift #(.CNT_W(CNT_W)) i_shift (
        .clk(clk), .rst(rst), .active(~cs_q), .start(cs_fall),
        .sck_rise(sck_rise), .sck_fall(sck_fall), .si_s(si_s),
        .load(status), .so_bit(so_bit), .rx_word(rx_word), .len_ok(len_ok)
    );

    spi_cmd_regs i_regs (
        .clk(clk), .rst(rst), .commit(cs_rise & len_ok), .rx_cmd(cmd_t'(rx_word)),
        .flt_in(fault_in), .uv_in(uv_in), .ov_in(ov_in), .nib_in(stat_nib),
        .status(status), .stat_sel(stat_sel), .wr_en(reg_wr_en), .wr_data(reg_wr_data)
    );

    always_ff @(posedge clk) begin
        if (rst) oe_q <= 1'b0;
        else     oe_q <= ~cs_q;
    end

    assign so_oe = oe_q;
    assign so    = oe_q & so_bit;

    logic unused_sck;
    assign unused_sck = sck_q;
endmodule

// File: rtl/spi_status_chk.sv
module spi_status_chk import spi_stat_pkg::*; (
    input logic              clk,
    input logic              rst,
    input logic              cs_n,
    input logic              so,
    input logic              so_oe,
    input logic [SEL_W-1:0]  stat_sel,
    input logic [NREG-1:0]   reg_wr_en,
    input logic [WORD_W-1:0] reg_wr_data
);
    logic [2:0] cyc;
    always_ff @(posedge clk) begin
        if (rst)            cyc <= '0;
        else if (cyc != '1) cyc <= cyc + 1'b1;
    end

    p_oe_off_r2: assert property (@(posedge clk) disable iff (rst)
        (cyc >= 3'd5 && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3)
         && $past(cs_n, 4) && $past(cs_n, 5)) |-> (!so_oe && !so));

    p_onehot_r4: assert property (@(posedge clk) disable iff (rst)
        $onehot0(reg_wr_en));

    p_addr_r4: assert property (@(posedge clk) disable iff (rst)
        (reg_wr_en != '0) |-> (reg_wr_en == (NREG'(1) << reg_wr_data[WORD_W-1 -: ADDR_W])));

    p_pulse_r4: assert property (@(posedge clk) disable iff (rst)
        (reg_wr_en != '0) |=> (reg_wr_en == '0));

    p_end_r4: assert property (@(posedge clk) disable iff (rst)
        (reg_wr_en != '0) |-> !so_oe);

    p_sel_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (cyc != '0 && !$stable(stat_sel)) |-> reg_wr_en[SEL_ADDR]);

    p_sel_val_r10: assert property (@(posedge clk) disable iff (rst)
        reg_wr_en[SEL_ADDR] |-> (stat_sel == reg_wr_data[SEL_W-1:0]));
endmodule

bind spi_status_frontend spi_status_chk i_chk (
    .clk(clk), .rst(rst), .cs_n(cs_n), .so(so), .so_oe(so_oe),
    .stat_sel(stat_sel), .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data)
);

// File: tb/test_spi_status_frontend.sv
module test_spi_status_frontend;
    logic clk = 1'b0, rst = 1'b1;
    logic sclk = 1'b0, cs_n = 1'b1, si = 1'b0;
    logic so, so_oe, uv_in = 1'b0, ov_in = 1'b0;
    logic [3:0]  fault_in = '0, stat_nib;
    logic [4:0]  stat_sel;
    logic [7:0]  reg_wr_en;
    logic [15:0] reg_wr_data;

    int n_chk = 0, n_bad = 0, n_stb = 0;
    logic [7:0]  last_en;
    logic [15:0] last_dat;

    logic [15:0] m_prev = '0;
    logic [4:0]  m_sel = '0;
    logic [3:0]  m_flt = '0;
    logic        m_uv = 1'b0, m_ov = 1'b0;

    always #5 clk = ~clk;
    assign stat_nib = stat_sel[3:0] ^ 4'h5;

    spi_status_frontend i_spi_status_frontend (
        .clk(clk), .rst(rst), .sclk(sclk), .cs_n(cs_n), .si(si), .so(so), .so_oe(so_oe),
        .fault_in(fault_in), .uv_in(uv_in), .ov_in(ov_in), .stat_nib(stat_nib),
        .stat_sel(stat_sel), .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data)
    );

    always @(posedge clk) if (!rst && reg_wr_en != '0) begin
        n_stb++; last_en = reg_wr_en; last_dat = reg_wr_data;
    end

    task automatic check(input logic [47:0] act, input logic [47:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_status();
        return {m_prev[12], m_uv, m_ov, m_prev[4:0], m_flt, m_sel[3:0] ^ 4'h5};
    endfunction

    task automatic run_frame(input logic [47:0] din, input int n, output logic [47:0] dout);
        dout = '0;
        @(negedge clk) cs_n = 1'b0;
        repeat (8) @(negedge clk);
        check({47'd0, so_oe}, 48'd1, "R2 so_oe during frame");
        for (int i = n - 1; i >= 0; i--) begin
            si = din[i];
            repeat (8) @(negedge clk);
            dout[i] = so;
            sclk = 1'b1;
            repeat (8) @(negedge clk);
            sclk = 1'b0;
        end
        repeat (8) @(negedge clk);
        cs_n = 1'b1;
        repeat (10) @(negedge clk);
    endtask

    task automatic accept(input logic [15:0] w);
        m_prev = w;
        if (w[15:13] == 3'd0) m_sel = w[4:0];
        m_flt = fault_in; m_uv = uv_in; m_ov = ov_in;
    endtask

    task automatic do_cmd(input logic [15:0] w, input string tag);
        logic [47:0] got;
        int s0 = n_stb;
        logic [15:0] e = exp_status();
        run_frame({32'd0, w}, 16, got);
        check(got[15:0], {32'd0, e}, {tag, " R7 R11 status word"});
        check(n_stb - s0, 1, {tag, " R4 one strobe"});
        check({last_en, last_dat}, {32'd0, 8'd1 << w[15:13], w}, {tag, " R4 strobe/data"});
        accept(w);
        check(stat_sel, m_sel, {tag, " R10 stat_sel"});
    endtask

    task automatic t_reset();
        check({so_oe, so}, 0, "R1 R2 output idle after reset");
        check(reg_wr_en, 0, "R1 no strobe");
        check(stat_sel, 0, "R1 stat_sel");
    endtask

    task automatic t_basic();
        do_cmd(16'h3A5F, "basic1");
        do_cmd(16'h5C0B, "basic2");
        do_cmd(16'hE7E1, "basic3");
    endtask

    task automatic t_select();
        do_cmd(16'h0013, "sel_write");
        do_cmd(16'h4FFC, "sel_other_addr");
        do_cmd(16'h1008, "sel_write2");
        do_cmd(16'h2000, "sel_after");
    endtask

    task automatic t_invalid(input int n, input string tag);
        logic [47:0] got;
        int s0 = n_stb;
        logic [4:0] sel0 = stat_sel;
        run_frame(48'h0000_0001_F00F, n, got);
        check(n_stb - s0, 0, {tag, " R3 R5 no strobe"});
        check(stat_sel, sel0, {tag, " R5 stat_sel held"});
    endtask

    task automatic t_chain();
        logic [47:0] got;
        int s0 = n_stb;
        logic [15:0] e = exp_status();
        run_frame({16'd0, 16'hA5C3, 16'h0016}, 32, got);
        check(got[31:16], {32'd0, e}, "R11 chain status first");
        check(got[15:0], 48'hA5C3, "R6 echo of first 16 SI bits");
        check(n_stb - s0, 1, "R3 32-bit frame valid");
        check(last_dat, 48'h0016, "R4 last 16 bits latched");
        accept(16'h0016);
        check(stat_sel, 48'h16, "R10 stat_sel from chained frame");
    endtask

    task automatic t_flags();
        @(negedge clk) fault_in = 4'b1010; uv_in = 1'b1;
        repeat (6) @(negedge clk);
        fault_in = 4'b0000; uv_in = 1'b0; ov_in = 1'b1;
        repeat (6) @(negedge clk);
        ov_in = 1'b0;
        m_flt = 4'b1010; m_uv = 1'b1; m_ov = 1'b1;
        repeat (4) @(negedge clk);
        do_cmd(16'h6001, "flags_R8_R9_set");
        t_invalid(15, "flags_invalid");
        do_cmd(16'h6002, "flags_R8_R9_cleared");
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        t_reset();
        t_basic();
        t_select();
        t_invalid(15, "short15");
        t_invalid(17, "long17");
        t_invalid(0, "empty");
        do_cmd(16'h2222, "after_invalid_R5");
        t_chain();
        do_cmd(16'h0000, "post_chain");
        t_flags();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule